// File: doc/BRIEF.md
# SCSI Controller Control and Interrupt Registers

This block is the processor-facing register file of a SCSI bus controller. A CPU reaches it over a small address bus with 8-bit write and read data. It holds three control registers: a mode register, an initiator command register and a target command register. From these it drives the bus control lines and the data-bus enable as active-high asserts. Open-collector, active-low conversion happens outside the block. The phase sequencer, the DMA data path and the arbitration timer are separate blocks. They only feed events in: the sampled BSY level, an end-of-process pulse and a parity-error pulse.

The block merges four interrupt causes into one latched interrupt line:

- a software-issued bus reset;
- an unexpected drop of BSY while BSY monitoring is on;
- an end-of-process pulse while its enable is set;
- a parity error while both parity checking and the parity interrupt are enabled.

The latch stays set until the CPU reads the interrupt-acknowledge address. Two register side effects carry the main behaviour:

- Setting the bus-reset command bit wipes every control register and the parity latch, but not the interrupt latch or the reset bit itself.
- A monitored loss of BSY clears the command bits and drops every bus line the block drives.

Top module: `scsi_ctl_regs`

## Requirements
- R1: After the external active-low reset `rst_n`, every register, the parity latch and the interrupt latch read 0, and every bus output and `irq_o` is 0.
- R2: The command register is at address 1, readable as {reset bit, 0, 0, bits 4..0}. Its bits are 0 data-bus enable, 1 ATN, 2 SEL, 3 BSY, 4 ACK and 7 bus reset. The mode register is at address 2 and reads back exactly what was written. The target command register is at address 3, in bits 3..0 (0 I/O, 1 C/D, 2 MSG, 3 REQ). Status is at address 4, reading {00000, sampled BSY, interrupt latch, parity latch}. Any other address reads 0, except address 7.
- R3: Writing 1 to command bit 7 drives `bus_rst_o`. It stays high until a command write with bit 7 at 0 or an external reset.
- R4: The write that sets the reset bit also sets the interrupt latch. While the reset bit is 1, the mode register, the target command register, command bits 4..0 and the parity latch are held at 0, and writes to them are ignored.
- R5: With mode bit 2 (monitor BSY) set, a 1-to-0 change of `bsy_in` between two clock edges does three things at the second edge. It sets the interrupt latch, clears command bits 4..0 and clears the target command register. From that edge on, every bus line except reset is deasserted. With mode bit 2 clear, the same change has no effect.
- R6: An `eop_in` pulse sets the interrupt latch only while mode bit 3 is set.
- R7: A `par_err_in` pulse sets the parity latch (status bit 0) only while mode bit 5 (parity checking) is set.
- R8: A `par_err_in` pulse sets the interrupt latch only when mode bits 4 and 5 are both set.
- R9: With mode bit 6 clear (initiator role), C/D, I/O, MSG and REQ stay low. With it set (target role), ATN and ACK stay low. SEL, BSY and the data-bus enable follow their command bits in both roles.
- R10: A read at address 7 returns the status byte and clears the interrupt latch at the next edge. Reads at other addresses leave the latch unchanged.
- R11: When an interrupt source fires in the same cycle as the acknowledge read, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External asynchronous reset, active low |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe, one cycle per read |
| cpu_rdata | output | 8 | Read data for cpu_addr (combinational) |
| bsy_in | input | 1 | Sampled BSY level on the SCSI bus |
| eop_in | input | 1 | End-of-process pulse from DMA logic |
| par_err_in | input | 1 | Parity error pulse for a received byte |
| bus_rst_o | output | 1 | Assert RST |
| bus_atn_o | output | 1 | Assert ATN |
| bus_ack_o | output | 1 | Assert ACK |
| bus_sel_o | output | 1 | Assert SEL |
| bus_bsy_o | output | 1 | Assert BSY |
| bus_dbus_o | output | 1 | Enable data-bus drivers |
| bus_cd_o | output | 1 | Assert C/D |
| bus_io_o | output | 1 | Assert I/O |
| bus_msg_o | output | 1 | Assert MSG |
| bus_req_o | output | 1 | Assert REQ |
| irq_o | output | 1 | Interrupt latch output |

## Verification
The bench builds the block with its default parameters: a 3-bit address and the command, mode, target, status and acknowledge registers at addresses 1, 2, 3, 4 and 7. This map lets random 3-bit addresses reach every register, the acknowledge read and the unmapped holes. With this map, random write data regularly sets the reset bit, the monitor bit and the role bit. That makes wipes, monitored BSY drops and role switches collide with ordinary writes and event pulses in the same cycle.

// File: rtl/scsi_reg_pkg.sv
package scsi_reg_pkg;
  // command register bit positions (decoded by the bus driver)
  localparam int CMD_DBUS = 0;
  localparam int CMD_ATN  = 1;
  localparam int CMD_SEL  = 2;
  localparam int CMD_BSY  = 3;
  localparam int CMD_ACK  = 4;
  localparam int CMD_RST  = 7;
  localparam int CMD_LOW_W = 5;
  // mode register bit positions
  localparam int MD_ARB    = 0;
  localparam int MD_DMA    = 1;
  localparam int MD_MONBSY = 2;
  localparam int MD_EOPIE  = 3;
  localparam int MD_PARIE  = 4;
  localparam int MD_PARCHK = 5;
  localparam int MD_TGT    = 6;
  localparam int MD_BLK    = 7;
  // target command bit positions
  localparam int TC_IO  = 0;
  localparam int TC_CD  = 1;
  localparam int TC_MSG = 2;
  localparam int TC_REQ = 3;
  localparam int TC_W   = 4;

  function automatic logic [7:0] cmd_view(input logic rst, input logic [CMD_LOW_W-1:0] low);
    return {rst, 2'b00, low};
  endfunction

  function automatic logic [7:0] status_view(input logic bsy, input logic irq, input logic par);
    return {5'b00000, bsy, irq, par};
  endfunction
endpackage

// File: rtl/scsi_ctl_cmd.sv
module scsi_ctl_cmd
  import scsi_reg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cmd,
  input  logic                 wr_mode,
  input  logic                 wr_tcmd,
  input  logic [7:0]           wdata,
  input  logic                 bsy_in,
  output logic [CMD_LOW_W-1:0] cmd_low,
  output logic                 rst_bit,
  output logic [7:0]           mode,
  output logic [TC_W-1:0]      tcmd,
  output logic                 rst_set_ev,
  output logic                 bsy_loss_ev,
  output logic                 wipe
);
  logic bsy_q;
  logic rst_next;

  assign rst_next    = wr_cmd ? wdata[CMD_RST] : rst_bit;
  assign wipe        = rst_next;
  assign rst_set_ev  = wr_cmd && wdata[CMD_RST] && !rst_bit;
  assign bsy_loss_ev = mode[MD_MONBSY] && bsy_q && !bsy_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy_q   <= 1'b0;
      rst_bit <= 1'b0;
      cmd_low <= '0;
      mode    <= '0;
      tcmd    <= '0;
    end else begin
      bsy_q   <= bsy_in;
      rst_bit <= rst_next;
      if (wipe || bsy_loss_ev)  cmd_low <= '0;
      else if (wr_cmd)          cmd_low <= wdata[CMD_LOW_W-1:0];
      if (wipe)                 mode <= '0;
      else if (wr_mode)         mode <= wdata;
      if (wipe || bsy_loss_ev)  tcmd <= '0;
      else if (wr_tcmd)         tcmd <= wdata[TC_W-1:0];
    end
  end

  p_rst_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit && !(wr_cmd && !wdata[CMD_RST]) |=> rst_bit);

  p_rst_wipes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit |-> (mode == '0) && (tcmd == '0) && (cmd_low == '0));

  p_bsy_loss_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_loss_ev |=> (cmd_low == '0) && (tcmd == '0));
endmodule

// File: rtl/scsi_ctl_irq.sv
module scsi_ctl_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en_eop,
  input  logic en_par_irq,
  input  logic en_par_chk,
  input  logic eop_in,
  input  logic par_err_in,
  input  logic rst_set_ev,
  input  logic bsy_loss_ev,
  input  logic wipe,
  input  logic ack_rd,
  output logic irq,
  output logic par_latch,
  output logic set_ev
);
  logic eop_ev;
  logic par_irq_ev;

  assign eop_ev     = eop_in && en_eop;
  assign par_irq_ev = par_err_in && en_par_chk && en_par_irq;
  assign set_ev     = rst_set_ev || bsy_loss_ev || eop_ev || par_irq_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      par_latch <= 1'b0;
    end else begin
      if (set_ev)      irq <= 1'b1;
      else if (ack_rd) irq <= 1'b0;
      if (wipe)                          par_latch <= 1'b0;
      else if (par_err_in && en_par_chk) par_latch <= 1'b1;
    end
  end

  p_eop_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eop_in && en_eop |=> irq);

  p_par_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !par_latch && !en_par_chk |=> !par_latch);

  p_par_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_in && en_par_chk && en_par_irq |=> irq);

  p_irq_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack_rd |=> irq);

  p_irq_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && !set_ev |=> !irq);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && set_ev |=> irq);
endmodule

// File: rtl/scsi_ctl_drive.sv
module scsi_ctl_drive
  import scsi_reg_pkg::*;
(
  input  logic                 tgt_role,
  input  logic                 rst_bit,
  input  logic [CMD_LOW_W-1:0] cmd_low,
  input  logic [TC_W-1:0]      tcmd,
  output logic                 drv_rst,
  output logic                 drv_atn,
  output logic                 drv_ack,
  output logic                 drv_sel,
  output logic                 drv_bsy,
  output logic                 drv_dbus,
  output logic [TC_W-1:0]      drv_tgt
);
  assign drv_rst  = rst_bit;
  assign drv_sel  = cmd_low[CMD_SEL];
  assign drv_bsy  = cmd_low[CMD_BSY];
  assign drv_dbus = cmd_low[CMD_DBUS];
  assign drv_atn  = cmd_low[CMD_ATN] && !tgt_role;
  assign drv_ack  = cmd_low[CMD_ACK] && !tgt_role;

  for (genvar i = 0; i < TC_W; i++) begin : g_tgt
    assign drv_tgt[i] = tcmd[i] && tgt_role;
  end
endmodule

// File: rtl/scsi_ctl_regs.sv
module scsi_ctl_regs
  import scsi_reg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CMD_ADDR  = 1,
  parameter int MODE_ADDR = 2,
  parameter int TCMD_ADDR = 3,
  parameter int STAT_ADDR = 4,
  parameter int IACK_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  input  logic              bsy_in,
  input  logic              eop_in,
  input  logic              par_err_in,
  output logic              bus_rst_o,
  output logic              bus_atn_o,
  output logic              bus_ack_o,
  output logic              bus_sel_o,
  output logic              bus_bsy_o,
  output logic              bus_dbus_o,
  output logic              bus_cd_o,
  output logic              bus_io_o,
  output logic              bus_msg_o,
  output logic              bus_req_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] A_TCMD = ADDR_W'(TCMD_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_IACK = ADDR_W'(IACK_ADDR);

  logic                 wr_cmd, wr_mode, wr_tcmd, ack_rd;
  logic [CMD_LOW_W-1:0] cmd_low;
  logic                 rst_bit;
  logic [7:0]           mode;
  logic [TC_W-1:0]      tcmd;
  logic                 rst_set_ev, bsy_loss_ev, wipe;
  logic                 irq, par_latch, set_ev;
  logic [TC_W-1:0]      drv_tgt;

  assign wr_cmd  = cpu_wr && (cpu_addr == A_CMD);
  assign wr_mode = cpu_wr && (cpu_addr == A_MODE);
  assign wr_tcmd = cpu_wr && (cpu_addr == A_TCMD);
  assign ack_rd  = cpu_rd && (cpu_addr == A_IACK);

  scsi_ctl_cmd u_cmd (
    .clk(clk), .rst_n(rst_n),
    .wr_cmd(wr_cmd), .wr_mode(wr_mode), .wr_tcmd(wr_tcmd),
    .wdata(cpu_wdata), .bsy_in(bsy_in),
    .cmd_low(cmd_low), .rst_bit(rst_bit), .mode(mode), .tcmd(tcmd),
    .rst_set_ev(rst_set_ev), .bsy_loss_ev(bsy_loss_ev), .wipe(wipe)
  );

  scsi_ctl_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .en_eop(mode[MD_EOPIE]), .en_par_irq(mode[MD_PARIE]), .en_par_chk(mode[MD_PARCHK]),
    .eop_in(eop_in), .par_err_in(par_err_in),
    .rst_set_ev(rst_set_ev), .bsy_loss_ev(bsy_loss_ev), .wipe(wipe), .ack_rd(ack_rd),
    .irq(irq), .par_latch(par_latch), .set_ev(set_ev)
  );

  scsi_ctl_drive u_drv (
    .tgt_role(mode[MD_TGT]), .rst_bit(rst_bit), .cmd_low(cmd_low), .tcmd(tcmd),
    .drv_rst(bus_rst_o), .drv_atn(bus_atn_o), .drv_ack(bus_ack_o),
    .drv_sel(bus_sel_o), .drv_bsy(bus_bsy_o), .drv_dbus(bus_dbus_o),
    .drv_tgt(drv_tgt)
  );

  assign bus_io_o  = drv_tgt[TC_IO];
  assign bus_cd_o  = drv_tgt[TC_CD];
  assign bus_msg_o = drv_tgt[TC_MSG];
  assign bus_req_o = drv_tgt[TC_REQ];
  assign irq_o     = irq;

  always_comb begin
    cpu_rdata = 8'h00;
    if (cpu_addr == A_CMD)       cpu_rdata = cmd_view(rst_bit, cmd_low);
    else if (cpu_addr == A_MODE) cpu_rdata = mode;
    else if (cpu_addr == A_TCMD) cpu_rdata = {{(8-TC_W){1'b0}}, tcmd};
    else if (cpu_addr == A_STAT || cpu_addr == A_IACK)
      cpu_rdata = status_view(bsy_in, irq, par_latch);
  end

  p_init_role_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[MD_TGT] |-> !(bus_cd_o || bus_io_o || bus_msg_o || bus_req_o));

  p_tgt_role_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode[MD_TGT] |-> !(bus_atn_o || bus_ack_o));

  p_rst_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst_o) |-> irq_o);

  p_loss_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_loss_ev |=> !(bus_atn_o || bus_ack_o || bus_sel_o || bus_bsy_o || bus_dbus_o
                     || bus_cd_o || bus_io_o || bus_msg_o || bus_req_o) && irq_o);
endmodule

// File: tb/scsi_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module scsi_ctl_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_rdata;
  logic bsy_in = 1'b0, eop_in = 1'b0, par_err_in = 1'b0;
  logic b_rst, b_atn, b_ack, b_sel, b_bsy, b_dbus, b_cd, b_io, b_msg, b_req, irq_o;

  always #5 clk = ~clk;

  scsi_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .bsy_in(bsy_in), .eop_in(eop_in), .par_err_in(par_err_in),
    .bus_rst_o(b_rst), .bus_atn_o(b_atn), .bus_ack_o(b_ack), .bus_sel_o(b_sel),
    .bus_bsy_o(b_bsy), .bus_dbus_o(b_dbus), .bus_cd_o(b_cd), .bus_io_o(b_io),
    .bus_msg_o(b_msg), .bus_req_o(b_req), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic       m_rst, m_irq, m_par, m_bq;
  logic [4:0] m_low;
  logic [7:0] m_mode;
  logic [3:0] m_tc;

  function automatic logic [10:0] exp_outs();
    logic t = m_mode[6];
    return {m_rst, m_low[1] & ~t, m_low[4] & ~t, m_low[2], m_low[3], m_low[0],
            m_tc[1] & t, m_tc[0] & t, m_tc[2] & t, m_tc[3] & t, m_irq};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd1: return {m_rst, 2'b00, m_low};
      3'd2: return m_mode;
      3'd3: return {4'h0, m_tc};
      3'd4, 3'd7: return {5'b0, bsy_in, m_irq, m_par};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [10:0] act_outs();
    return {b_rst, b_atn, b_ack, b_sel, b_bsy, b_dbus, b_cd, b_io, b_msg, b_req, irq_o};
  endfunction

  task automatic model_clear();
    m_rst = 0; m_irq = 0; m_par = 0; m_bq = 0; m_low = '0; m_mode = '0; m_tc = '0;
  endtask

  task automatic model_edge();
    logic nrst, rset, loss, setv;
    nrst = (cpu_wr && cpu_addr == 3'd1) ? cpu_wdata[7] : m_rst;
    rset = cpu_wr && cpu_addr == 3'd1 && cpu_wdata[7] && !m_rst;
    loss = m_mode[2] && m_bq && !bsy_in;
    setv = rset || loss || (eop_in && m_mode[3]) || (par_err_in && m_mode[5] && m_mode[4]);
    if (setv) m_irq = 1;
    else if (cpu_rd && cpu_addr == 3'd7) m_irq = 0;
    if (nrst) m_par = 0;
    else if (par_err_in && m_mode[5]) m_par = 1;
    if (nrst || loss) m_low = '0;
    else if (cpu_wr && cpu_addr == 3'd1) m_low = cpu_wdata[4:0];
    if (nrst || loss) m_tc = '0;
    else if (cpu_wr && cpu_addr == 3'd3) m_tc = cpu_wdata[3:0];
    if (nrst) m_mode = '0;
    else if (cpu_wr && cpu_addr == 3'd2) m_mode = cpu_wdata;
    m_rst = nrst;
    m_bq = bsy_in;
  endtask

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model follows the edge, outputs and read data compared at the next negedge
  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " outs"}, act_outs(), exp_outs());
    chk({tag, " rdata"}, {3'b0, cpu_rdata}, {3'b0, exp_rd(cpu_addr)});
  endtask

  task automatic op(input string tag, input logic w, input logic r, input logic [2:0] a, input logic [7:0] d);
    cpu_wr = w; cpu_rd = r; cpu_addr = a; cpu_wdata = d;
    tick(tag);
    cpu_wr = 0; cpu_rd = 0; eop_in = 0; par_err_in = 0;
  endtask

  task automatic peek(input string tag, input logic [2:0] a, input logic [7:0] exp);
    cpu_addr = a; #1;
    chk(tag, {3'b0, cpu_rdata}, {3'b0, exp});
  endtask

  task automatic ext_reset();
    @(negedge clk);
    rst_n = 0; model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 outputs after reset", act_outs(), 11'h000);
    peek("R1 cmd reads 0", 3'd1, 8'h00);
    peek("R1 mode reads 0", 3'd2, 8'h00);
    peek("R1 status reads 0", 3'd4, 8'h00);

    // R2 register map and readback
    op("R2 mode write", 1, 0, 3'd2, 8'hA3);
    peek("R2 mode readback", 3'd2, 8'hA3);
    op("R2 tcmd write", 1, 0, 3'd3, 8'hF5);
    peek("R2 tcmd readback", 3'd3, 8'h05);
    op("R2 cmd write", 1, 0, 3'd1, 8'h7F);
    peek("R2 cmd readback", 3'd1, 8'h1F);
    peek("R2 hole reads 0", 3'd5, 8'h00);

    // R9 roles
    op("R9 target role", 1, 0, 3'd2, 8'h40);
    op("R9 tcmd all", 1, 0, 3'd3, 8'h0F);
    op("R9 cmd all", 1, 0, 3'd1, 8'h1F);
    chk("R9 target lines", act_outs(), 11'b0_00_111_1111_0);
    op("R9 initiator role", 1, 0, 3'd2, 8'h00);
    chk("R9 initiator lines", act_outs(), 11'b0_11_111_0000_0);

    // R3 / R4 software bus reset
    op("R4 set mode", 1, 0, 3'd2, 8'h20);
    par_err_in = 1;
    op("R7 parity latched", 0, 0, 3'd0, 8'h00);
    peek("R7 parity status", 3'd4, 8'h01);
    op("R3 set reset bit", 1, 0, 3'd1, 8'h9F);
    chk("R4 reset sets irq, wipes lines", act_outs(), 11'b1_00_000_0000_1);
    peek("R4 mode wiped", 3'd2, 8'h00);
    peek("R4 parity wiped", 3'd4, 8'h02);
    op("R4 mode write ignored", 1, 0, 3'd2, 8'h55);
    peek("R4 mode still 0", 3'd2, 8'h00);
    op("R3 idle", 0, 0, 3'd0, 8'h00);
    op("R3 idle", 0, 0, 3'd0, 8'h00);
    chk("R3 rst held", {10'b0, b_rst}, 11'd1);
    op("R3 release", 1, 0, 3'd1, 8'h03);
    chk("R3 rst released", {10'b0, b_rst}, 11'd0);
    peek("R3 low bits loaded on release", 3'd1, 8'h03);

    // R10 acknowledge
    op("R10 other read keeps irq", 0, 1, 3'd2, 8'h00);
    chk("R10 irq kept", {10'b0, irq_o}, 11'd1);
    op("R10 ack read", 0, 1, 3'd7, 8'h00);
    chk("R10 irq cleared", {10'b0, irq_o}, 11'd0);

    // R3 external reset ends bus reset
    op("R3 set again", 1, 0, 3'd1, 8'h80);
    ext_reset();
    chk("R3 ext reset clears rst", act_outs(), 11'h000);

    // R5 monitored BSY loss
    bsy_in = 1;
    op("R5 mode monitor", 1, 0, 3'd2, 8'h44);
    op("R5 tcmd", 1, 0, 3'd3, 8'h0F);
    op("R5 cmd", 1, 0, 3'd1, 8'h1F);
    bsy_in = 0;
    op("R5 bsy drop", 0, 0, 3'd0, 8'h00);
    chk("R5 lines released, irq", act_outs(), 11'b0_00_000_0000_1);
    peek("R5 cmd cleared", 3'd1, 8'h00);
    peek("R5 mode kept", 3'd2, 8'h44);
    op("R5 ack", 0, 1, 3'd7, 8'h00);
    bsy_in = 1;
    op("R5 unmonitored mode", 1, 0, 3'd2, 8'h00);
    op("R5 cmd", 1, 0, 3'd1, 8'h1F);
    bsy_in = 0;
    op("R5 unmonitored drop", 0, 0, 3'd0, 8'h00);
    peek("R5 cmd kept", 3'd1, 8'h1F);
    chk("R5 no irq", {10'b0, irq_o}, 11'd0);

    // R6 end of process
    eop_in = 1;
    op("R6 eop disabled", 0, 0, 3'd0, 8'h00);
    chk("R6 no irq", {10'b0, irq_o}, 11'd0);
    op("R6 enable", 1, 0, 3'd2, 8'h08);
    eop_in = 1;
    op("R6 eop enabled", 0, 0, 3'd0, 8'h00);
    chk("R6 irq", {10'b0, irq_o}, 11'd1);

    // R11 collision of source and acknowledge
    eop_in = 1;
    op("R11 eop with ack", 0, 1, 3'd7, 8'h00);
    chk("R11 irq stays", {10'b0, irq_o}, 11'd1);
    op("R11 plain ack", 0, 1, 3'd7, 8'h00);

    // R7 / R8 parity gating
    op("R7 checking off", 1, 0, 3'd2, 8'h10);
    par_err_in = 1;
    op("R7 parity ignored", 0, 0, 3'd0, 8'h00);
    peek("R7 no latch", 3'd4, 8'h00);
    op("R8 check only", 1, 0, 3'd2, 8'h20);
    par_err_in = 1;
    op("R8 parity no irq", 0, 0, 3'd0, 8'h00);
    peek("R8 latch, no irq", 3'd4, 8'h01);
    op("R8 both", 1, 0, 3'd2, 8'h30);
    par_err_in = 1;
    op("R8 parity irq", 0, 0, 3'd0, 8'h00);
    peek("R8 irq set", 3'd4, 8'h03);

    // random traffic against the reference model
    void'($urandom(32'h5C51));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (($urandom % 8) != 0) d[7] = 1'b0;
      if (($urandom % 12) == 0) bsy_in = ~bsy_in;
      eop_in = (($urandom % 16) == 0);
      par_err_in = (($urandom % 10) == 0);
      op("R2/R9 random", (($urandom % 3) == 0), (($urandom % 5) == 0), 3'($urandom), d);
    end
    report();
  end
endmodule